// File: doc/BRIEF.md
# Streaming Pixel XOR Cipher

This block scrambles or unscrambles a raster stream of 3-bit colour pixels, one pixel per valid cycle, in row-major order. Bit 2 of a pixel is the red component, bit 1 is green and bit 0 is blue. Each pixel is combined bit by bit with a 3-bit key word using the sum-of-products form (P AND NOT K) OR (NOT P AND K), which is exclusive-OR. Running the cipher stream through the block again with the same key sequence gives back the original pixels. Each output pixel keeps the row and column slot of its input pixel.

Two key sources are available. In fixed-key mode, a 3-bit user key from three push buttons is applied to every pixel. In table mode, the key comes from a nine-entry table that is loaded through a write port. A rotating pointer indexes the table, and it is stepped before each pixel is combined, so a frame starts at entry 1. A registered output stage then picks the ciphered pixel, the plain pixel or black.

Top module: `pix_xor_cipher`

## Requirements
- R1: Each output bit is (P AND NOT K) OR (NOT P AND K) of the matching pixel and key bits. With key 101, plain 100 gives 001, 101 gives 000, 110 gives 011 and 111 gives 010.
- R2: `out_valid` equals `pix_valid` delayed by one clock. The result for a pixel appears on `out_pix` in the cycle after that pixel is accepted.
- R3: When `en_cipher` is high, the output is the ciphered pixel, whatever the value of `en_plain`.
- R4: When `en_plain` is high and `en_cipher` is low, the pixel passes through unchanged.
- R5: When both enables are low, the output pixel is 000 (black).
- R6: When `mode_table` is 0, every pixel uses `user_key` as its key.
- R7: When `mode_table` is 1, the pointer steps before each pixel is combined and wraps from 8 to 0. After reset or a frame start, pixels therefore use table entries 1, 2, …, 8, 0, 1, …, repeating every nine pixels.
- R8: The pointer steps on every cycle with `pix_valid` high, in either mode, and on no other cycle. Idle cycles and time spent in fixed-key mode do not break the table sequence.
- R9: A `sof` pulse returns the pointer to 0. A pixel presented in the same cycle as `sof` uses entry 1.
- R10: A write with `kt_we` high stores `kt_wdata` at entry `kt_addr` at the clock edge. Writes to addresses 9 and above change nothing.
- R11: Feeding the cipher output back in, with the same key sequence from a new frame start, restores the original pixels.
- R12: In cycles without `pix_valid`, `out_pix` holds its previous value.
- R13: During reset, `out_valid` is 0 and `out_pix` is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Frame-start pulse; clears the key pointer |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | PIX_W | Input pixel (bit 2 red, bit 1 green, bit 0 blue) |
| mode_table | input | 1 | 1 selects the key table, 0 selects the user key |
| user_key | input | PIX_W | Fixed key from the push buttons |
| kt_we | input | 1 | Key table write enable |
| kt_addr | input | KEY_AW | Key table write address |
| kt_wdata | input | PIX_W | Key table write data |
| en_plain | input | 1 | Selects the plain pixel at the output |
| en_cipher | input | 1 | Selects the ciphered pixel at the output (takes priority) |
| out_valid | output | 1 | Output pixel strobe |
| out_pix | output | PIX_W | Registered output pixel |

## Verification
The assertions assume that enables, mode and user key are stable in every cycle with `pix_valid` high, and that reset is a clean synchronous pulse. The bench changes configuration only right after an idle cycle, so that assumption always holds. Table contents are checked only after every entry has been written, because the storage is not reset. The bench also drives zero pixels in table mode so that each output shows the selected key entry directly.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  typedef enum logic [1:0] {
    SEL_BLACK  = 2'd0,
    SEL_PLAIN  = 2'd1,
    SEL_CIPHER = 2'd2
  } osel_e;

  // cipher enable wins over plain enable
  function automatic osel_e pick_sel(input logic en_p, input logic en_c);
    if (en_c)      return SEL_CIPHER;
    else if (en_p) return SEL_PLAIN;
    else           return SEL_BLACK;
  endfunction
endpackage

// File: rtl/pxc_key_ptr.sv
module pxc_key_ptr #(
  parameter int DEPTH = 9,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sof,
  input  logic          adv,
  output logic [PW-1:0] ptr_use
);
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_base;

  // pointer steps first, then the stepped value selects the key
  always_comb begin
    ptr_base = sof ? '0 : ptr_q;
    if (ptr_base == PW'(DEPTH - 1)) ptr_use = '0;
    else                            ptr_use = ptr_base + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)      ptr_q <= '0;
    else if (adv) ptr_q <= ptr_use;
    else if (sof) ptr_q <= '0;
  end
endmodule

// File: rtl/pxc_key_table.sv
module pxc_key_table #(
  parameter int DEPTH = 9,
  parameter int W     = 3,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pxc_sop_xor.sv
module pxc_sop_xor #(
  parameter int W = 3
) (
  input  logic [W-1:0] plain,
  input  logic [W-1:0] key,
  output logic [W-1:0] cipher
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign cipher[b] = (plain[b] & ~key[b]) | (~plain[b] & key[b]);
  end
endmodule

// File: rtl/pxc_out_stage.sv
module pxc_out_stage
  import pxc_pkg::*;
#(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         en_p,
  input  logic         en_c,
  input  logic [W-1:0] plain,
  input  logic [W-1:0] cipher,
  output logic         out_valid,
  output logic [W-1:0] out_pix
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        case (pick_sel(en_p, en_c))
          SEL_CIPHER: out_pix <= cipher;
          SEL_PLAIN:  out_pix <= plain;
          default:    out_pix <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pix_xor_cipher.sv
module pix_xor_cipher #(
  parameter int PIX_W     = 3,
  parameter int KEY_DEPTH = 9,
  parameter int KEY_AW    = $clog2(KEY_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              mode_table,
  input  logic [PIX_W-1:0]  user_key,
  input  logic              kt_we,
  input  logic [KEY_AW-1:0] kt_addr,
  input  logic [PIX_W-1:0]  kt_wdata,
  input  logic              en_plain,
  input  logic              en_cipher,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_pix
);
  logic [KEY_AW-1:0] ptr_use;
  logic [PIX_W-1:0]  tbl_key;
  logic [PIX_W-1:0]  key_sel;
  logic [PIX_W-1:0]  cipher;

  pxc_key_ptr #(.DEPTH(KEY_DEPTH), .PW(KEY_AW)) u_ptr (
    .clk(clk), .rst(rst), .sof(sof), .adv(pix_valid), .ptr_use(ptr_use)
  );

  pxc_key_table #(.DEPTH(KEY_DEPTH), .W(PIX_W), .AW(KEY_AW)) u_tbl (
    .clk(clk), .we(kt_we), .waddr(kt_addr), .wdata(kt_wdata),
    .raddr(ptr_use), .rdata(tbl_key)
  );

  assign key_sel = mode_table ? tbl_key : user_key;

  pxc_sop_xor #(.W(PIX_W)) u_sop (
    .plain(pix_data), .key(key_sel), .cipher(cipher)
  );

  pxc_out_stage #(.W(PIX_W)) u_out (
    .clk(clk), .rst(rst), .in_valid(pix_valid), .en_p(en_plain),
    .en_c(en_cipher), .plain(pix_data), .cipher(cipher),
    .out_valid(out_valid), .out_pix(out_pix)
  );
endmodule

// File: rtl/pxc_checker.sv
module pxc_checker #(
  parameter int PIX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_valid,
  input logic [PIX_W-1:0] pix_data,
  input logic             mode_table,
  input logic [PIX_W-1:0] user_key,
  input logic             en_plain,
  input logic             en_cipher,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_pix
);
  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(pix_valid)));

  // R5
  black_out_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !en_plain && !en_cipher) |=> (out_pix == '0));

  // R4
  plain_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && en_plain && !en_cipher) |=> (out_pix == $past(pix_data)));

  // R6 (also R3: cipher wins regardless of en_plain)
  fixed_key_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && en_cipher && !mode_table) |=>
      (out_pix == ($past(pix_data) ^ $past(user_key))));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> $stable(out_pix));

  // R13
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && (out_pix == '0)));
endmodule

bind pix_xor_cipher pxc_checker #(.PIX_W(PIX_W)) u_pxc_chk (
  .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_data(pix_data),
  .mode_table(mode_table), .user_key(user_key), .en_plain(en_plain),
  .en_cipher(en_cipher), .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/test_pix_xor_cipher.sv
`timescale 1ns/1ps
module test_pix_xor_cipher;
  localparam int PW = 3;
  localparam int KD = 9;
  localparam int KA = $clog2(KD);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, sof = 1'b0, pix_valid = 1'b0, mode_table = 1'b0;
  logic kt_we = 1'b0, en_plain = 1'b0, en_cipher = 1'b0;
  logic [PW-1:0] pix_data = '0, user_key = '0, kt_wdata = '0;
  logic [KA-1:0] kt_addr = '0;
  logic out_valid;
  logic [PW-1:0] out_pix;

  pix_xor_cipher i_pix_xor_cipher (
    .clk(clk), .rst(rst), .sof(sof), .pix_valid(pix_valid), .pix_data(pix_data),
    .mode_table(mode_table), .user_key(user_key), .kt_we(kt_we), .kt_addr(kt_addr),
    .kt_wdata(kt_wdata), .en_plain(en_plain), .en_cipher(en_cipher),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  int errs = 0, checks = 0;
  bit done = 1'b0;
  logic [PW-1:0] kt_m [KD];
  int ptr_m = 0;
  logic [PW-1:0] exp_q[$];
  string tag_q[$];
  logic vin_d = 1'b0;
  logic [PW-1:0] last_out = '0;

  task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  always @(posedge clk) vin_d <= rst ? 1'b0 : pix_valid;

  // monitor: pops the scoreboard on every output strobe
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2", PW'(out_valid), PW'(vin_d));
      if (out_valid) begin
        if (exp_q.size() == 0) chk("R2 spurious output", 1, 0);
        else begin
          logic [PW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, out_pix, e);
        end
        last_out = out_pix;
      end else begin
        chk("R12", out_pix, last_out);
      end
    end
  end

  task automatic send(input logic [PW-1:0] px, input logic s, input string tag,
                      input int force_exp = -1);
    logic [PW-1:0] k, e;
    @(negedge clk);
    pix_valid = 1'b1; pix_data = px; sof = s;
    if (s) ptr_m = 0;
    ptr_m = (ptr_m == KD - 1) ? 0 : ptr_m + 1;
    k = mode_table ? kt_m[ptr_m] : user_key;
    e = en_cipher ? (px ^ k) : (en_plain ? px : '0);
    if (force_exp >= 0) e = PW'(force_exp);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      pix_valid = 1'b0; sof = 1'b0;
    end
  endtask

  task automatic kt_write(input int a, input logic [PW-1:0] d);
    @(negedge clk);
    kt_we = 1'b1; kt_addr = KA'(a); kt_wdata = d;
    if (a < KD) kt_m[a] = d;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 out_valid", PW'(out_valid), 0);
    chk("R13 out_pix", out_pix, 0);
    mode_table = 1'b0; user_key = 3'b101; en_cipher = 1'b1; en_plain = 1'b0;
    rst = 1'b0;

    // R1 worked values with key 101
    send(3'b100, 0, "R1", 1);
    send(3'b101, 0, "R1", 0);
    send(3'b110, 0, "R1", 3);
    send(3'b111, 0, "R1", 2);
    idle(2);
    user_key = 3'b011;
    for (int i = 0; i < 8; i++) send(PW'(i), 0, "R6");
    idle(1);
    en_cipher = 1'b0; en_plain = 1'b1;
    for (int i = 0; i < 4; i++) send(PW'(7 - i), 0, "R4");
    idle(1);
    en_plain = 1'b0;
    for (int i = 0; i < 3; i++) send(PW'(i + 5), 0, "R5");
    idle(1);
    en_plain = 1'b1; en_cipher = 1'b1; user_key = 3'b110;
    for (int i = 0; i < 4; i++) send(PW'(i * 3), 0, "R3");
    idle(2);

    // load the key table; the out-of-range writes must be ignored (R10)
    for (int i = 0; i < KD; i++) kt_write(i, PW'((i * 5 + 3) % 8));
    kt_write(9, 3'b111);
    kt_write(15, 3'b111);
    @(negedge clk) kt_we = 1'b0;
    en_plain = 1'b0; en_cipher = 1'b1; mode_table = 1'b1;

    // R7: zero pixels expose the key sequence; first pixel shares sof (R9)
    send('0, 1, "R9");
    for (int i = 1; i < 19; i++) send('0, 0, "R7");
    idle(2);

    // R10: rewrite one entry, ignored write to 12
    kt_write(4, 3'b110);
    kt_write(12, 3'b001);
    @(negedge clk) kt_we = 1'b0;
    send('0, 1, "R10");
    for (int i = 1; i < 9; i++) send('0, 0, "R10");
    idle(1);

    // R8: gaps and fixed-mode pixels keep the sequence stepping
    send('0, 1, "R8");
    send('0, 0, "R8");
    idle(3);
    send('0, 0, "R8");
    send(3'b010, 0, "R8");
    idle(1);
    mode_table = 1'b0; user_key = 3'b000;
    send(3'b101, 0, "R8");
    send(3'b011, 0, "R8");
    idle(1);
    mode_table = 1'b1;
    for (int i = 0; i < 6; i++) send('0, 0, "R8");
    idle(1);

    // R9: frame start mid-stream restarts at entry 1
    for (int i = 0; i < 5; i++) send(PW'(i), 0, "R9");
    send(3'b000, 1, "R9");
    send(3'b000, 0, "R9");
    idle(2);

    // R11: cipher fed back with the same key sequence gives the plain back
    for (int n = 0; n < 11; n++) send(PW'(n % 8), n == 0, "R11");
    idle(1);
    for (int n = 0; n < 11; n++)
      send(PW'(n % 8) ^ kt_m[(n + 1) % KD], n == 0, "R11", n % 8);
    idle(5);

    chk("R2 queue drained", (exp_q.size() == 0) ? 1 : 0, 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule